// File: doc/BRIEF.md
# Mixed-Width Dual-Port Memory

This block is a true dual-port memory of 18,432 bits: 16,384 data bits and 2,048 parity bits. Each of its two ports has a clock, an enable, a write enable, an address, write data and read data. Each port has a width fixed by a parameter: 1, 2, 4, 9 or 18 bits. The two widths may differ, and both ports view the same stored bits. A narrow port reaches the data bits at a finer grain than a wide port. Only the 9-bit and 18-bit shapes reach the parity bits.

Reads and writes are both synchronous. A port samples its request on the rising edge of its own clock and shows the result on its read data after that edge. On a write, the read data shows the word that was just written. Either port may read or write, so the block can serve as a single-port RAM with one port idle, or as a full dual-port RAM.

Top module: `mw_dpram`

## Requirements
- R1: A port of width W (1, 2, 4, 9 or 18) has 16384/D addressable words, where D is W for W of 1, 2 or 4, D is 8 for W=9 and D is 16 for W=18. The lowest and highest addresses are both usable.
- R2: Bit i of the data part of the word at address a is stored data bit a*D+i, with the least significant bit first. A word written through one port width reads back through any other width at the matching data bits.
- R3: In a 9-bit word, bit 8 is stored parity bit a. In an 18-bit word, bits 16 and 17 are stored parity bits 2a and 2a+1. The data bits occupy the low D bits of the word.
- R4: Writes through a 1-, 2- or 4-bit port never change any parity bit.
- R5: When a port has enable high and write enable low at a rising edge, its read data shows the stored word at that address after that edge, one cycle of latency.
- R6: When a port has enable and write enable both high at a rising edge, its read data shows the written word after that edge (write-first).
- R7: When a port's enable is low, its read data holds its value and its write enable has no effect on the stored bits.
- R8: Both ports may write in the same cycle. When they touch disjoint bits, including disjoint bits of one storage row, both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of port A |
| en_a | input | 1 | Port A request enable |
| we_a | input | 1 | Port A write enable (used when en_a is high) |
| addr_a | input | AW_A | Port A word address |
| din_a | input | WIDTH_A | Port A write word |
| dout_a | output | WIDTH_A | Port A registered read word |
| clk_b | input | 1 | Clock of port B |
| en_b | input | 1 | Port B request enable |
| we_b | input | 1 | Port B write enable (used when en_b is high) |
| addr_b | input | AW_B | Port B word address |
| din_b | input | WIDTH_B | Port B write word |
| dout_b | output | WIDTH_B | Port B registered read word |

## Verification
The hardest case to reach is two ports writing in the same cycle to different bits of the same storage row. Both writes must survive, even though each port rewrites a whole row. The stimulus sets this up with a 9-bit port and a 1-bit port whose addresses fall into one row without overlapping bits, then reads both words back. A second hard case is showing that parity bits are untouched by narrow writes. The bench rewrites every nibble of one row through the 4-bit port and reads the row's parity back through the 18-bit port. It also flips single bits through the 1-bit port and reads them back through the 9-bit port.

// File: rtl/mw_dpram_pkg.sv
package mw_dpram_pkg;

  // Data bits carried by a word of the given port width.
  function automatic int data_w(int w);
    return (w == 18) ? 16 : (w == 9) ? 8 : w;
  endfunction

  // Parity bits carried by a word of the given port width.
  function automatic int par_w(int w);
    return (w == 18) ? 2 : (w == 9) ? 1 : 0;
  endfunction

endpackage

// File: rtl/mw_lane_map.sv
// Maps one port's word address onto a storage row: which row, which bits
// of that row, the placed write value, and the word extracted from a row.
module mw_lane_map
  import mw_dpram_pkg::*;
#(
  parameter int W        = 18,
  parameter int AW       = 10,
  parameter int ROW_DATA = 16,
  parameter int ROW_W    = 18,
  parameter int RAW      = 10
)(
  input  logic [AW-1:0]    addr_i,
  input  logic [W-1:0]     din_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [RAW-1:0]   row_o,
  output logic [ROW_W-1:0] mask_o,
  output logic [ROW_W-1:0] wval_o,
  output logic [W-1:0]     word_o
);
  localparam int DW  = data_w(W);
  localparam int PW  = par_w(W);
  localparam int WPR = ROW_DATA / DW;

  int unsigned slot, sh_d, sh_p;

  always_comb begin
    row_o = RAW'(32'(addr_i) / WPR);
    slot  = 32'(addr_i) % WPR;
    sh_d  = slot * DW;
    sh_p  = ROW_DATA + slot * PW;
  end

  logic [ROW_W-1:0] d_ones, d_ext, p_ones, p_ext;
  logic [DW-1:0]    d_rd;

  assign d_ones = ROW_W'({DW{1'b1}});
  assign d_ext  = ROW_W'(din_i[DW-1:0]);
  assign d_rd   = DW'(row_i >> sh_d);

  if (PW > 0) begin : g_par
    logic [PW-1:0] p_rd;
    assign p_ones = ROW_W'({PW{1'b1}});
    assign p_ext  = ROW_W'(din_i[W-1:DW]);
    assign p_rd   = PW'(row_i >> sh_p);
    assign word_o = {p_rd, d_rd};
  end else begin : g_nopar
    assign p_ones = '0;
    assign p_ext  = '0;
    assign word_o = d_rd;
  end

  assign mask_o = (d_ones << sh_d) | (p_ones << sh_p);
  assign wval_o = (d_ext << sh_d) | (p_ext << sh_p);

endmodule

// File: rtl/mw_bank.sv
// Row-organised storage bank with one masked write port and two
// asynchronous row reads.
module mw_bank #(
  parameter int ROWS  = 1024,
  parameter int ROW_W = 18,
  localparam int RAW  = $clog2(ROWS)
)(
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [RAW-1:0]   wrow_i,
  input  logic [ROW_W-1:0] mask_i,
  input  logic [ROW_W-1:0] wdata_i,
  input  logic [RAW-1:0]   rrow0_i,
  input  logic [RAW-1:0]   rrow1_i,
  output logic [ROW_W-1:0] rdata0_o,
  output logic [ROW_W-1:0] rdata1_o
);
  logic [ROW_W-1:0] mem [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wrow_i] <= (mem[wrow_i] & ~mask_i) | (wdata_i & mask_i);
  end

  assign rdata0_o = mem[rrow0_i];
  assign rdata1_o = mem[rrow1_i];

endmodule

// File: rtl/mw_out_reg.sv
// Per-port read register with write-first behaviour and hold when idle.
module mw_out_reg #(
  parameter int W = 18
)(
  input  logic         clk_i,
  input  logic         en_i,
  input  logic         we_i,
  input  logic [W-1:0] din_i,
  input  logic [W-1:0] rword_i,
  output logic [W-1:0] dout_o
);
  always_ff @(posedge clk_i) begin
    if (en_i) dout_o <= we_i ? din_i : rword_i;
  end
endmodule

// File: rtl/mw_dpram.sv
module mw_dpram
  import mw_dpram_pkg::*;
#(
  parameter int WIDTH_A   = 18,
  parameter int WIDTH_B   = 4,
  parameter int DATA_BITS = 16384,
  parameter int PAR_BITS  = 2048,
  parameter int ROW_DATA  = 16,
  localparam int AW_A = $clog2(DATA_BITS / data_w(WIDTH_A)),
  localparam int AW_B = $clog2(DATA_BITS / data_w(WIDTH_B))
)(
  input  logic               clk_a,
  input  logic               en_a,
  input  logic               we_a,
  input  logic [AW_A-1:0]    addr_a,
  input  logic [WIDTH_A-1:0] din_a,
  output logic [WIDTH_A-1:0] dout_a,
  input  logic               clk_b,
  input  logic               en_b,
  input  logic               we_b,
  input  logic [AW_B-1:0]    addr_b,
  input  logic [WIDTH_B-1:0] din_b,
  output logic [WIDTH_B-1:0] dout_b
);
  localparam int ROWS    = DATA_BITS / ROW_DATA;
  localparam int ROW_PAR = PAR_BITS / ROWS;
  localparam int ROW_W   = ROW_DATA + ROW_PAR;
  localparam int RAW     = $clog2(ROWS);

  // Named internal events, also used by the bound checker.
  logic             wr_a, wr_b;
  logic [ROW_W-1:0] mask_a, mask_b;
  logic [ROW_W-1:0] wval_a, wval_b;
  logic [RAW-1:0]   row_a, row_b;
  logic [WIDTH_A-1:0] rword_a;
  logic [WIDTH_B-1:0] rword_b;

  assign wr_a = en_a & we_a;
  assign wr_b = en_b & we_b;

  logic [1:0]       clk_v, wr_v;
  logic [RAW-1:0]   row_v  [2];
  logic [ROW_W-1:0] mask_v [2];
  logic [ROW_W-1:0] wval_v [2];
  logic [ROW_W-1:0] comb_v [2];
  logic [ROW_W-1:0] q      [2][2];   // q[bank][reader port]

  assign clk_v     = {clk_b, clk_a};
  assign wr_v      = {wr_b, wr_a};
  assign row_v[0]  = row_a;
  assign row_v[1]  = row_b;
  assign mask_v[0] = mask_a;
  assign mask_v[1] = mask_b;
  assign wval_v[0] = wval_a;
  assign wval_v[1] = wval_b;

  mw_lane_map #(.W(WIDTH_A), .AW(AW_A), .ROW_DATA(ROW_DATA), .ROW_W(ROW_W), .RAW(RAW)) u_map_a (
    .addr_i(addr_a), .din_i(din_a), .row_i(comb_v[0]),
    .row_o(row_a), .mask_o(mask_a), .wval_o(wval_a), .word_o(rword_a)
  );

  mw_lane_map #(.W(WIDTH_B), .AW(AW_B), .ROW_DATA(ROW_DATA), .ROW_W(ROW_W), .RAW(RAW)) u_map_b (
    .addr_i(addr_b), .din_i(din_b), .row_i(comb_v[1]),
    .row_o(row_b), .mask_o(mask_b), .wval_o(wval_b), .word_o(rword_b)
  );

  // Each bank has a single writer; the stored bit is the XOR of both banks,
  // so a writer stores its value XOR the other bank's current bit.
  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [ROW_W-1:0] wdat;
    assign wdat = wval_v[g] ^ q[1-g][g];

    mw_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
      .clk_i(clk_v[g]), .we_i(wr_v[g]), .wrow_i(row_v[g]),
      .mask_i(mask_v[g]), .wdata_i(wdat),
      .rrow0_i(row_v[0]), .rrow1_i(row_v[1]),
      .rdata0_o(q[g][0]), .rdata1_o(q[g][1])
    );

    assign comb_v[g] = q[0][g] ^ q[1][g];
  end

  mw_out_reg #(.W(WIDTH_A)) u_out_a (
    .clk_i(clk_a), .en_i(en_a), .we_i(we_a), .din_i(din_a), .rword_i(rword_a), .dout_o(dout_a)
  );

  mw_out_reg #(.W(WIDTH_B)) u_out_b (
    .clk_i(clk_b), .en_i(en_b), .we_i(we_b), .din_i(din_b), .rword_i(rword_b), .dout_o(dout_b)
  );

endmodule

// File: rtl/mw_dpram_chk.sv
module mw_dpram_chk
  import mw_dpram_pkg::*;
#(
  parameter int WIDTH_A  = 18,
  parameter int WIDTH_B  = 4,
  parameter int ROW_W    = 18,
  parameter int ROW_DATA = 16
)(
  input logic               clk_a,
  input logic               en_a,
  input logic               we_a,
  input logic [WIDTH_A-1:0] din_a,
  input logic [WIDTH_A-1:0] dout_a,
  input logic               wr_a,
  input logic [ROW_W-1:0]   mask_a,
  input logic               clk_b,
  input logic               en_b,
  input logic               we_b,
  input logic [WIDTH_B-1:0] din_b,
  input logic [WIDTH_B-1:0] dout_b,
  input logic               wr_b,
  input logic [ROW_W-1:0]   mask_b
);
  // R6: write-first read data
  p_write_first_a_r6: assert property (@(posedge clk_a) (en_a && we_a) |=> dout_a == $past(din_a));
  p_write_first_b_r6: assert property (@(posedge clk_b) (en_b && we_b) |=> dout_b == $past(din_b));

  // R7: idle port holds its read data
  p_idle_hold_a_r7: assert property (@(posedge clk_a) !en_a |=> $stable(dout_a));
  p_idle_hold_b_r7: assert property (@(posedge clk_b) !en_b |=> $stable(dout_b));

  // R1: a write touches exactly one word's worth of stored bits
  p_mask_size_a_r1: assert property (@(posedge clk_a) wr_a |-> $countones(mask_a) == WIDTH_A);
  p_mask_size_b_r1: assert property (@(posedge clk_b) wr_b |-> $countones(mask_b) == WIDTH_B);

  // R4: narrow ports never reach the parity columns
  if (par_w(WIDTH_A) == 0) begin : g_guard_a
    p_parity_guard_a_r4: assert property (@(posedge clk_a) wr_a |-> mask_a[ROW_W-1:ROW_DATA] == '0);
  end
  if (par_w(WIDTH_B) == 0) begin : g_guard_b
    p_parity_guard_b_r4: assert property (@(posedge clk_b) wr_b |-> mask_b[ROW_W-1:ROW_DATA] == '0);
  end
endmodule

bind mw_dpram mw_dpram_chk #(
  .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B), .ROW_W(ROW_W), .ROW_DATA(ROW_DATA)
) u_chk (
  .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .din_a(din_a), .dout_a(dout_a),
  .wr_a(wr_a), .mask_a(mask_a),
  .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .din_b(din_b), .dout_b(dout_b),
  .wr_b(wr_b), .mask_b(mask_b)
);

// File: tb/mw_dpram_test.sv
`timescale 1ns/1ps
module mw_dpram_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Instance 0: 18-bit port A, 4-bit port B
  logic        en_a0, we_a0, en_b0, we_b0;
  logic [9:0]  addr_a0;
  logic [17:0] din_a0, dout_a0;
  logic [11:0] addr_b0;
  logic [3:0]  din_b0, dout_b0;
  // Instance 1: 9-bit port A, 1-bit port B
  logic        en_a1, we_a1, en_b1, we_b1;
  logic [10:0] addr_a1;
  logic [8:0]  din_a1, dout_a1;
  logic [13:0] addr_b1;
  logic [0:0]  din_b1, dout_b1;

  mw_dpram #(.WIDTH_A(18), .WIDTH_B(4)) uut (
    .clk_a(clk), .en_a(en_a0), .we_a(we_a0), .addr_a(addr_a0), .din_a(din_a0), .dout_a(dout_a0),
    .clk_b(clk), .en_b(en_b0), .we_b(we_b0), .addr_b(addr_b0), .din_b(din_b0), .dout_b(dout_b0)
  );

  mw_dpram #(.WIDTH_A(9), .WIDTH_B(1)) uut_n (
    .clk_a(clk), .en_a(en_a1), .we_a(we_a1), .addr_a(addr_a1), .din_a(din_a1), .dout_a(dout_a1),
    .clk_b(clk), .en_b(en_b1), .we_b(we_b1), .addr_b(addr_b1), .din_b(din_b1), .dout_b(dout_b1)
  );

  // Bit-level reference: data and parity regions per instance
  logic [16383:0] md [2];
  logic [2047:0]  mp [2];
  logic [17:0]    last_exp [4];

  typedef struct {
    int          inst;
    int          port;
    logic [17:0] exp;
    int          due;
    string       tag;
  } sb_t;
  sb_t sbq [$];

  function automatic int wid(int k);
    return (k == 0) ? 18 : (k == 1) ? 4 : (k == 2) ? 9 : 1;
  endfunction

  function automatic int dwid(int w);
    if (w == 18) return 16;
    if (w == 9)  return 8;
    return w;
  endfunction

  function automatic logic [17:0] m_read(int inst, int w, int a);
    int dw = dwid(w);
    logic [17:0] r = '0;
    for (int i = 0; i < dw; i++) r[i] = md[inst][a*dw + i];
    if (w == 9) r[8] = mp[inst][a];
    if (w == 18) begin
      r[16] = mp[inst][2*a];
      r[17] = mp[inst][2*a + 1];
    end
    return r;
  endfunction

  function automatic void m_write(int inst, int w, int a, logic [17:0] d);
    int dw = dwid(w);
    for (int i = 0; i < dw; i++) md[inst][a*dw + i] = d[i];
    if (w == 9) mp[inst][a] = d[8];
    if (w == 18) begin
      mp[inst][2*a]     = d[16];
      mp[inst][2*a + 1] = d[17];
    end
  endfunction

  function automatic logic [17:0] get_dout(int k);
    case (k)
      0:       return dout_a0;
      1:       return {14'b0, dout_b0};
      2:       return {9'b0, dout_a1};
      default: return {17'b0, dout_b1};
    endcase
  endfunction

  function automatic logic [17:0] pat(int a, int s);
    return 18'(a * 97 + s * 1234 + (a << 7)) ^ 18'h15A5A;
  endfunction

  task automatic idle_all();
    en_a0 = 0; we_a0 = 0; en_b0 = 0; we_b0 = 0;
    en_a1 = 0; we_a1 = 0; en_b1 = 0; we_b1 = 0;
  endtask

  // Driver: sets one port for the coming edge and queues its expectation.
  task automatic op(int inst, int port, bit en, bit we, int a, logic [17:0] d, string tag);
    int k = inst * 2 + port;
    int w = wid(k);
    logic [17:0] dm = d & ((18'h1 << w) - 18'h1);
    sb_t it;
    case (k)
      0: begin en_a0 = en; we_a0 = we; addr_a0 = 10'(a); din_a0 = dm; end
      1: begin en_b0 = en; we_b0 = we; addr_b0 = 12'(a); din_b0 = dm[3:0]; end
      2: begin en_a1 = en; we_a1 = we; addr_a1 = 11'(a); din_a1 = dm[8:0]; end
      default: begin en_b1 = en; we_b1 = we; addr_b1 = 14'(a); din_b1 = dm[0:0]; end
    endcase
    if (en) begin
      it.exp = we ? dm : m_read(inst, w, a);
      last_exp[k] = it.exp;
      if (we) m_write(inst, w, a, dm);
    end else begin
      it.exp = last_exp[k];
    end
    it.inst = inst; it.port = port; it.due = cyc + 1; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle_all();
  endtask

  // Monitor: compares queued expectations one cycle after they were driven.
  always @(negedge clk) begin
    sb_t it;
    logic [17:0] got;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      it  = sbq.pop_front();
      got = get_dout(it.inst * 2 + it.port);
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s inst%0d port%0d actual=%h expected=%h", it.tag, it.inst, it.port, got, it.exp);
      end
    end
  end

  initial begin
    idle_all();
    addr_a0 = '0; din_a0 = '0; addr_b0 = '0; din_b0 = '0;
    addr_a1 = '0; din_a1 = '0; addr_b1 = '0; din_b1 = '0;
    repeat (4) @(negedge clk);

    // R6: fill both memories through their widest ports; each write echoes
    for (int a = 0; a < 2048; a++) begin
      op(1, 0, 1, 1, a, pat(a, 1), "R6");
      if (a < 1024) op(0, 0, 1, 1, a, pat(a, 0), "R6");
      tick();
    end

    // R2: read back through the narrow ports (cross-width mapping)
    for (int a = 0; a < 64; a++) begin
      op(0, 1, 1, 0, a, 18'h0, "R2");
      op(1, 1, 1, 0, a * 3, 18'h0, "R2");
      tick();
    end

    // R3: wide reads including parity bits
    for (int a = 0; a < 32; a++) begin
      op(0, 0, 1, 0, a * 31, 18'h0, "R3");
      op(1, 0, 1, 0, a * 63 + 1, 18'h0, "R3");
      tick();
    end

    // R4: rewrite every nibble of row 7 through the 4-bit port, parity must stay
    for (int a = 28; a < 32; a++) begin
      op(0, 1, 1, 1, a, 18'(~a), "R4");
      tick();
    end
    op(0, 0, 1, 0, 7, 18'h0, "R4");
    tick();
    // R4: flip bits 24..31 through the 1-bit port, 9-bit word 3 keeps its parity
    for (int b = 24; b < 32; b++) begin
      op(1, 1, 1, 1, b, {17'b0, ~md[1][b]}, "R4");
      tick();
    end
    op(1, 0, 1, 0, 3, 18'h0, "R4");
    tick();

    // R5: back-to-back reads return each address one cycle later
    for (int a = 100; a < 104; a++) begin
      op(0, 0, 1, 0, a, 18'h0, "R5");
      op(1, 1, 1, 0, a * 5, 18'h0, "R5");
      tick();
    end

    // R7: disabled port ignores write enable and holds its output
    op(0, 0, 0, 1, 200, 18'h3FFFF, "R7");
    op(1, 0, 0, 1, 200, 18'h1FF, "R7");
    tick();
    op(0, 1, 0, 1, 800, 18'hF, "R7");
    tick();
    op(0, 0, 1, 0, 200, 18'h0, "R7");
    op(1, 0, 1, 0, 200, 18'h0, "R7");
    tick();
    op(0, 1, 1, 0, 800, 18'h0, "R7");
    tick();

    // R8: simultaneous writes to disjoint bits of one row (9-bit word 6 and bit 56)
    op(1, 0, 1, 1, 6, 18'h0C3, "R8");
    op(1, 1, 1, 1, 56, {17'b0, ~md[1][56]}, "R8");
    tick();
    op(1, 0, 1, 0, 6, 18'h0, "R8");
    op(1, 1, 1, 0, 56, 18'h0, "R8");
    tick();
    op(1, 0, 1, 0, 7, 18'h0, "R8");
    tick();
    // R8: simultaneous writes to different rows through the 18- and 4-bit ports
    op(0, 0, 1, 1, 10, 18'h2D4E1, "R8");
    op(0, 1, 1, 1, 50, 18'h9, "R8");
    tick();
    op(0, 0, 1, 0, 10, 18'h0, "R8");
    op(0, 1, 1, 0, 50, 18'h0, "R8");
    tick();

    // R1: highest addresses on every port width
    op(0, 0, 1, 1, 1023, 18'h3A5C1, "R1");
    op(1, 0, 1, 1, 2047, 18'h155, "R1");
    tick();
    op(0, 1, 1, 1, 4095, 18'h6, "R1");
    op(1, 1, 1, 1, 16383, {17'b0, ~md[1][16383]}, "R1");
    tick();
    op(0, 0, 1, 0, 1023, 18'h0, "R1");
    op(1, 0, 1, 0, 2047, 18'h0, "R1");
    tick();
    op(0, 1, 1, 0, 4095, 18'h0, "R1");
    op(1, 1, 1, 0, 16383, 18'h0, "R1");
    op(0, 0, 1, 0, 0, 18'h0, "R1");
    op(1, 0, 1, 0, 0, 18'h0, "R1");
    tick();

    tick();
    tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule